// File: doc/BRIEF.md
# Approximate-Storage Access Mode Controller

This block stands in front of a memory request queue and labels every read or write with one of four access modes. The modes tell the bank datapath how to store pixel data whose neighbours look alike. Software loads a small table. Each entry holds an inclusive address window, a quality level and an enable bit. The first address of a window is the anchor pixel of that window. A write to the anchor is always stored exactly, and its 24-bit RGB value is kept inside the controller. Later writes in the same window are compared channel by channel with the kept anchor value. A write that is close enough is stored approximately, and one that is not falls back to a precise write. A read inside any enabled window is tagged as a copy, so the bank can fill the pixel from the anchor.

The table is programmed through a write-only port of four 32-bit words per entry: the low bound, the high bound, the quality level and the enable bit. Every window lookup runs in parallel across all entries. The request leaves the block one clock after it is accepted, with its direction, address and pixel unchanged and a 2-bit mode attached. The block has no back-pressure.

Top module: `amc_mode_ctrl`

## Requirements
- R1: Mode codes are 2'b00 precise write, 2'b01 precise read, 2'b10 approximate write and 2'b11 copy. A request whose address lies in no enabled window gets 2'b01 for a read (req_write=0) and 2'b00 for a write.
- R2: A read whose address lies in an enabled window gets mode 2'b11.
- R3: A write to the low bound of the matching window gets 2'b00 and records req_pixel as that entry's anchor value.
- R4: A write inside the matching window, not at its low bound, gets 2'b10 when the entry's anchor is recorded and each 8-bit channel (bits 23:16, 15:8, 7:0) differs from the anchor by at most the entry's threshold.
- R5: A write inside a window whose anchor is not recorded, or whose channel difference exceeds the threshold, gets 2'b00.
- R6: The quality level is 3 bits. Levels 1 to 6 give threshold 2^level (2, 4, 8, 16, 32, 64). Levels 0 and 7 give threshold 0, which means only an identical pixel is similar.
- R7: An entry matches when its enable bit is 1 and low <= addr <= high, with both bounds inclusive. When windows overlap, the lowest entry index decides the mode.
- R8: out_valid is high exactly in the cycle after a cycle with req_valid high. out_write, out_addr and out_pixel then repeat the accepted request.
- R9: After reset no entry is enabled, no anchor is recorded and out_valid is 0. Any configuration write to an entry clears that entry's anchor. Configuration word select is cfg_addr[1:0]: 0 low bound, 1 high bound, 2 level in bits 2:0, 3 enable in bit 0. The entry index is in the bits above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table register write strobe |
| cfg_addr | input | 4 | Entry index and word select |
| cfg_wdata | input | 32 | Table register write data |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Pixel address |
| req_pixel | input | 24 | RGB write data, 8 bits per channel |
| out_valid | output | 1 | Tagged request present |
| out_write | output | 1 | Direction of the tagged request |
| out_addr | output | 32 | Address of the tagged request |
| out_pixel | output | 24 | Pixel of the tagged request |
| out_mode | output | 2 | Assigned access mode |

## Verification
Directed requests are aimed at each window's bounds and one address past them. These separate an inclusive compare from an exclusive one, and a disabled entry from an enabled one. Pixels whose largest channel difference equals the threshold, or exceeds it by one, are written at several quality levels, including 0, 6 and 7. This exposes errors in the level-to-threshold mapping and in the similarity compare. Two windows overlap with different thresholds, so only the lowest-index entry gives the observed mode. Writes before the anchor and after a reprogramming show whether the anchor state is tracked and cleared. A seeded random mix of reads, anchor writes and near-anchor writes over reprogrammed tables is then compared against a bench model.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int CH_W   = 8;
  localparam int NUM_CH = 3;
  localparam int PIX_W  = CH_W * NUM_CH;
  localparam int LVL_W  = 3;
  localparam int MAX_LVL = 6;

  typedef enum logic [1:0] {
    MODE_PREC_WR   = 2'b00,
    MODE_PREC_RD   = 2'b01,
    MODE_APPROX_WR = 2'b10,
    MODE_COPY      = 2'b11
  } amc_mode_e;

  // Quality level to per-channel tolerance.
  function automatic logic [CH_W-1:0] level_threshold(input logic [LVL_W-1:0] lvl);
    logic [CH_W-1:0] th;
    th = '0;
    if (lvl >= LVL_W'(1) && lvl <= LVL_W'(MAX_LVL))
      th = CH_W'(1) << lvl;
    return th;
  endfunction

  function automatic logic [CH_W-1:0] chan_absdiff(input logic [CH_W-1:0] a,
                                                   input logic [CH_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // True when every channel is within the tolerance.
  function automatic logic pixels_similar(input logic [PIX_W-1:0] a,
                                          input logic [PIX_W-1:0] b,
                                          input logic [CH_W-1:0]  th);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_absdiff(a[c*CH_W +: CH_W], b[c*CH_W +: CH_W]) > th)
        ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic amc_mode_e pick_mode(input logic is_write,
                                          input logic in_window,
                                          input logic at_anchor,
                                          input logic anchor_known,
                                          input logic close_enough);
    amc_mode_e m;
    if (!in_window)
      m = is_write ? MODE_PREC_WR : MODE_PREC_RD;
    else if (!is_write)
      m = MODE_COPY;
    else if (!at_anchor && anchor_known && close_enough)
      m = MODE_APPROX_WR;
    else
      m = MODE_PREC_WR;
    return m;
  endfunction

endpackage

// File: rtl/amc_cfg_table.sv
module amc_cfg_table
  import amc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CFG_AW     = IDX_W + 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [DATA_W-1:0]                   cfg_wdata,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  lo_o,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  hi_o,
  output logic [NUM_ENTRIES-1:0][CH_W-1:0]    thresh_o,
  output logic [NUM_ENTRIES-1:0]              enable_o,
  output logic [NUM_ENTRIES-1:0]              touched_o
);

  localparam logic [1:0] W_LO  = 2'd0;
  localparam logic [1:0] W_HI  = 2'd1;
  localparam logic [1:0] W_LVL = 2'd2;
  localparam logic [1:0] W_EN  = 2'd3;

  logic [NUM_ENTRIES-1:0][LVL_W-1:0] lvl_q;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_word;

  assign wr_idx  = cfg_addr[CFG_AW-1:2];
  assign wr_word = cfg_addr[1:0];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    assign touched_o[i] = cfg_we && (wr_idx == IDX_W'(i));
    assign thresh_o[i]  = level_threshold(lvl_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_o[i]     <= '0;
        hi_o[i]     <= '0;
        lvl_q[i]    <= '0;
        enable_o[i] <= 1'b0;
      end else if (touched_o[i]) begin
        case (wr_word)
          W_LO:    lo_o[i]     <= cfg_wdata[ADDR_W-1:0];
          W_HI:    hi_o[i]     <= cfg_wdata[ADDR_W-1:0];
          W_LVL:   lvl_q[i]    <= cfg_wdata[LVL_W-1:0];
          W_EN:    enable_o[i] <= cfg_wdata[0];
          default: ;
        endcase
      end
    end

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      touched_o[i] && wr_word == W_EN |=> enable_o[i] == $past(cfg_wdata[0])); // R9

    AST_THRESH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      thresh_o[i] <= CH_W'(1 << MAX_LVL)); // R6
  end

  AST_TOUCH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(touched_o)); // R9

endmodule

// File: rtl/amc_range_match.sv
module amc_range_match #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  lo_i,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  hi_i,
  input  logic [NUM_ENTRIES-1:0]              enable_i,
  output logic [NUM_ENTRIES-1:0]              inside_o,
  output logic [NUM_ENTRIES-1:0]              sel_o,
  output logic                                hit_o,
  output logic [IDX_W-1:0]                    idx_o,
  output logic                                at_lo_o
);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign inside_o[i] = enable_i[i] && (addr_i >= lo_i[i]) && (addr_i <= hi_i[i]);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (inside_o[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_o = '0;
    if (hit_o) sel_o[idx_o] = 1'b1;
  end

  assign at_lo_o = hit_o && (addr_i == lo_i[idx_o]);

endmodule

// File: rtl/amc_anchor_store.sv
module amc_anchor_store
  import amc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rec_en_i,
  input  logic [IDX_W-1:0]                   rec_idx_i,
  input  logic [PIX_W-1:0]                   rec_pix_i,
  input  logic [NUM_ENTRIES-1:0]             clr_i,
  output logic [NUM_ENTRIES-1:0]             known_o,
  output logic [NUM_ENTRIES-1:0][PIX_W-1:0]  pix_o
);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_anchor
    logic rec_here;
    assign rec_here = rec_en_i && (rec_idx_i == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        known_o[i] <= 1'b0;
        pix_o[i]   <= '0;
      end else if (clr_i[i]) begin
        known_o[i] <= 1'b0;
      end else if (rec_here) begin
        known_o[i] <= 1'b1;
        pix_o[i]   <= rec_pix_i;
      end
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((known_o & $past(clr_i)) == '0)); // R9

  AST_RECORD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en_i && !clr_i[rec_idx_i] |=> known_o[$past(rec_idx_i)]); // R3

endmodule

// File: rtl/amc_mode_ctrl.sv
module amc_mode_ctrl
  import amc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int CFG_DW      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CFG_AW     = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PIX_W-1:0]   req_pixel,
  output logic               out_valid,
  output logic               out_write,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [PIX_W-1:0]   out_pixel,
  output logic [1:0]         out_mode
);

  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] win_lo, win_hi;
  logic [NUM_ENTRIES-1:0][CH_W-1:0]   win_th;
  logic [NUM_ENTRIES-1:0]             win_en, win_touched;
  logic [NUM_ENTRIES-1:0]             win_inside, win_sel;
  logic                               win_hit, at_anchor;
  logic [IDX_W-1:0]                   win_idx;
  logic [NUM_ENTRIES-1:0]             anc_known;
  logic [NUM_ENTRIES-1:0][PIX_W-1:0]  anc_pix;

  logic      sel_known, sel_close, anchor_rec;
  amc_mode_e mode_nxt;

  amc_cfg_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (CFG_DW)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lo_o      (win_lo),
    .hi_o      (win_hi),
    .thresh_o  (win_th),
    .enable_o  (win_en),
    .touched_o (win_touched)
  );

  amc_range_match #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W)
  ) u_match (
    .addr_i   (req_addr),
    .lo_i     (win_lo),
    .hi_i     (win_hi),
    .enable_i (win_en),
    .inside_o (win_inside),
    .sel_o    (win_sel),
    .hit_o    (win_hit),
    .idx_o    (win_idx),
    .at_lo_o  (at_anchor)
  );

  assign anchor_rec = req_valid && req_write && win_hit && at_anchor;

  amc_anchor_store #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_anchor (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_en_i  (anchor_rec),
    .rec_idx_i (win_idx),
    .rec_pix_i (req_pixel),
    .clr_i     (win_touched),
    .known_o   (anc_known),
    .pix_o     (anc_pix)
  );

  assign sel_known = anc_known[win_idx];
  assign sel_close = pixels_similar(req_pixel, anc_pix[win_idx], win_th[win_idx]);
  assign mode_nxt  = pick_mode(req_write, win_hit, at_anchor, sel_known, sel_close);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_addr  <= '0;
      out_pixel <= '0;
      out_mode  <= MODE_PREC_RD;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_write <= req_write;
        out_addr  <= req_addr;
        out_pixel <= req_pixel;
        out_mode  <= mode_nxt;
      end
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid && out_addr == $past(req_addr)); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R8

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel) && ((win_sel & ~win_inside) == '0)); // R7

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win_inside == '0 |=> out_mode == {1'b0, ~out_write}); // R1

  AST_READ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && win_inside != '0 |=> out_mode == MODE_COPY); // R2

  AST_ANCHOR_PRECISE: assert property (@(posedge clk) disable iff (!rst_n)
    anchor_rec |=> out_mode == MODE_PREC_WR); // R3

  AST_WRITE_NEVER_READMODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write |-> !out_mode[0]); // R4

  AST_UNKNOWN_ANCHOR_PRECISE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && win_hit && !sel_known |=> out_mode == MODE_PREC_WR); // R5

endmodule

// File: tb/amc_mode_ctrl_tb.sv
module amc_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [23:0] req_pixel = '0;
  logic        out_valid, out_write;
  logic [AW-1:0] out_addr;
  logic [23:0] out_pixel;
  logic [1:0]  out_mode;

  int n_total = 0;
  int n_fail  = 0;

  // bench model
  logic [AW-1:0] m_lo  [NE];
  logic [AW-1:0] m_hi  [NE];
  logic [2:0]    m_lvl [NE];
  logic          m_en  [NE];
  logic          m_kn  [NE];
  logic [23:0]   m_pix [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  amc_mode_ctrl u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .req_valid, .req_write, .req_addr, .req_pixel,
    .out_valid, .out_write, .out_addr, .out_pixel, .out_mode
  );

  function automatic int tol(input logic [2:0] l);
    case (l)
      3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
      3'd4: return 16;  3'd5: return 32;  3'd6: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic bit close(input logic [23:0] a, input logic [23:0] b, input int t);
    int worst = 0;
    for (int k = 0; k < 3; k++) begin
      int d = int'(a[8*k +: 8]) - int'(b[8*k +: 8]);
      if (d < 0) d = -d;
      if (d > worst) worst = d;
    end
    return worst <= t;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int e, input int w, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(e * 4 + w); cfg_wdata = d;
    m_kn[e] = 1'b0;
    case (w)
      0: m_lo[e] = d;
      1: m_hi[e] = d;
      2: m_lvl[e] = d[2:0];
      default: m_en[e] = d[0];
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int e, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [2:0] lvl, input bit en);
    cfg(e, 0, lo); cfg(e, 1, hi); cfg(e, 2, {29'd0, lvl}); cfg(e, 3, {31'd0, en});
  endtask

  // Drive one request at a negedge; check its tag at the next negedge.
  task automatic req(input string tag, input bit w, input logic [AW-1:0] a,
                     input logic [23:0] p);
    int hit = -1;
    logic [1:0] exp;
    for (int e = NE - 1; e >= 0; e--)
      if (m_en[e] && a >= m_lo[e] && a <= m_hi[e]) hit = e;
    if (hit < 0)       exp = w ? 2'b00 : 2'b01;
    else if (!w)       exp = 2'b11;
    else if (a == m_lo[hit]) begin
      exp = 2'b00; m_kn[hit] = 1'b1; m_pix[hit] = p;
    end else if (m_kn[hit] && close(p, m_pix[hit], tol(m_lvl[hit]))) exp = 2'b10;
    else               exp = 2'b00;
    req_valid = 1'b1; req_write = w; req_addr = a; req_pixel = p;
    @(negedge clk);
    check({tag, " mode"}, 64'(out_mode), 64'(exp));
    check("R8 valid", 64'(out_valid), 64'd1);
    check("R8 addr echo", 64'({out_write, out_addr, out_pixel}), 64'({w, a, p}));
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 idle valid", 64'(out_valid), 64'd0);
  endtask

  function automatic logic [23:0] nudge(input logic [23:0] b, input int span);
    logic [23:0] r;
    for (int k = 0; k < 3; k++) begin
      int v = int'(b[8*k +: 8]) + int'($urandom_range(2 * span)) - span;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      r[8*k +: 8] = 8'(v);
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < NE; e++) begin
      m_lo[e] = '0; m_hi[e] = '0; m_lvl[e] = '0; m_en[e] = 0; m_kn[e] = 0; m_pix[e] = '0;
    end
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 64'(out_valid), 64'd0);

    // R9/R1: empty table passes through
    req("R9 R1 empty read", 0, 32'h10, 24'h0);
    req("R9 R1 empty write", 1, 32'h0, 24'h123456);
    idle();

    prog(0, 32'h100, 32'h10F, 3'd3, 1);
    prog(1, 32'h108, 32'h120, 3'd6, 1);
    prog(2, 32'h200, 32'h2FF, 3'd5, 0);

    req("R5 before anchor", 1, 32'h104, 24'h102030);
    req("R2 read at low bound", 0, 32'h100, 24'h0);
    req("R3 anchor write", 1, 32'h100, 24'h102030);
    req("R4 R6 diff 8 lvl3", 1, 32'h104, 24'h182838);
    req("R5 R6 diff 9 lvl3", 1, 32'h10F, 24'h102039);
    req("R7 R5 entry1 no anchor", 1, 32'h110, 24'h102030);
    req("R7 past high bound", 0, 32'h121, 24'h0);
    req("R7 R2 at high bound", 0, 32'h120, 24'h0);
    req("R7 overlap low index", 1, 32'h10A, 24'h08182A);
    req("R7 disabled entry", 0, 32'h250, 24'h0);
    req("R7 below low bound", 1, 32'hFF, 24'h102030);
    idle();

    // R6 level 6 boundary on entry1
    req("R3 entry1 anchor", 1, 32'h108, 24'h808080);
    req("R6 lvl6 diff 64", 1, 32'h118, 24'hC04080);
    req("R6 lvl6 diff 65", 1, 32'h118, 24'hC18080);

    // R9 reprogram clears anchor; R6 level 0 exact only
    cfg(0, 2, 32'd0);
    req("R9 cleared anchor", 1, 32'h104, 24'h102030);
    req("R3 re-anchor", 1, 32'h100, 24'h55AA55);
    req("R6 lvl0 identical", 1, 32'h104, 24'h55AA55);
    req("R6 lvl0 diff 1", 1, 32'h104, 24'h55AA56);
    cfg(0, 2, 32'd7);
    req("R3 anchor lvl7", 1, 32'h100, 24'h010203);
    req("R6 lvl7 diff 1", 1, 32'h101, 24'h010204);
    idle();

    // seeded random mix
    for (int round = 0; round < 8; round++) begin
      for (int e = 0; e < NE; e++) begin
        logic [31:0] lo = 32'($urandom_range(200));
        prog(e, lo, lo + 32'($urandom_range(48)), 3'($urandom_range(7)),
             $urandom_range(9) < 8);
      end
      for (int n = 0; n < 60; n++) begin
        int pick = int'($urandom_range(9));
        int e = int'($urandom_range(NE - 1));
        logic [AW-1:0] a = 32'($urandom_range(255));
        if (pick < 3) req("R2 R1 rand read", 0, a, 24'h0);
        else if (pick < 5) req("R3 rand anchor", 1, m_lo[e], 24'($urandom));
        else if (pick < 9)
          req("R4 R5 rand near", 1, m_lo[e] + 32'($urandom_range(m_hi[e] - m_lo[e] + 1)),
              nudge(m_pix[e], 70));
        else idle();
      end
    end
    idle();

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule